// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides a single input clock by a ratio held in a bit field of a 32-bit control word. Software writes the word through a simple write port and can read it back. A small decoder turns the field into a divisor. A parameter picks one of four decodings:

- value plus one;
- the value itself;
- two raised to the value;
- an index into a parameter table, where a zero entry marks the index as unusable.

The field's position in the word is also a parameter.

A configured commit bit can make a write take effect only when that bit is set in the written word. Legal divisors go to a pending slot. The counter picks up the pending divisor at the end of the period that is running, so the output never shows a runt pulse. Illegal settings are refused: the error flag goes high and stays high, and the running divisor is kept. The output is never gated. A divisor of one routes the input clock straight to the output.

Top module: `ratio_divider`

## Requirements
- R1: After reset the error flag is 0, the readback word is 0 and the output divides by RST_DIV (default 2).
- R2: With the plus-one encoding (default), the divisor is the field value plus 1. The field sits at bits [FIELD_LSB+FIELD_W-1:FIELD_LSB], which defaults to bits [7:4].
- R3: With the direct encoding, the divisor equals the field value, and field 0 is illegal.
- R4: With the power-of-two encoding, the divisor is 2 to the power of the field value.
- R5: With the table encoding, the divisor is DIV_TABLE[field] (default entries 0:4, 1:8, 2:0, 3:6, 4:10). A zero entry is illegal and is never applied.
- R6: With every encoding except the table, a divisor below MIN_DIV or above MAX_DIV is illegal. The default MAX_DIV is 12.
- R7: Bits of the written word outside the field and the commit bit have no effect on the divisor.
- R8: With LATCH_EN=1, a write whose bit LATCH_BIT (default 31) is 0 only stores the word. A write with that bit set commits the field of that same word. With LATCH_EN=0, every write commits.
- R9: A commit of an illegal value sets cfg_err_o, which stays at 1 until reset, and the previous divisor keeps running.
- R10: For a divisor N of at least 2, each output period lasts N input cycles and is high for floor(N/2) of them, starting high.
- R11: A divisor of 1 makes div_clk_o follow clk_i.
- R12: reg_rdata_o returns the last written word, one cycle after the write.
- R13: A committed divisor starts at the next period boundary. The first full output period after the commit already has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low reset |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word to write |
| reg_rdata_o | output | 32 | Last written control word |
| div_clk_o | output | 1 | Divided clock |
| cfg_err_o | output | 1 | Sticky flag for an illegal setting |

## Verification
A write is taken at a rising edge. The readback word and the error flag change at that same edge, so the bench checks them at the falling edge that ends the write task.

A new divisor waits for the running period to end, which can take up to that period's length plus one cycle. The bench therefore waits 40 input cycles before it queues the expected high and period lengths. The monitor measures whole periods from samples taken 1 ns after each rising edge.

For R13 the bench does not wait. The monitor measures the first complete period after the commit, and it must already have the new length. Pass-through is checked just after both edges of the input clock.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Field-to-divisor decoding selected at build time
    typedef enum logic [1:0] {
        ENC_MINUS_ONE = 2'd0,
        ENC_DIRECT    = 2'd1,
        ENC_POW2      = 2'd2,
        ENC_TABLE     = 2'd3
    } enc_e;

endpackage

// File: rtl/rdiv_decode.sv
module rdiv_decode #(
    parameter rdiv_pkg::enc_e ENC = rdiv_pkg::ENC_MINUS_ONE,
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned DIV_W = 8,
    parameter int unsigned MIN_DIV = 1,
    parameter int unsigned MAX_DIV = 12,
    parameter logic [(1<<FIELD_W)-1:0][DIV_W-1:0] DIV_TABLE =
        128'h0000_0000_0000_0000_0000_000A_0600_0804
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [DIV_W-1:0]   div_o,
    output logic               legal_o
);

    // Wide intermediate so range checks see values beyond DIV_W
    logic [63:0] raw;

    generate
        if (ENC == rdiv_pkg::ENC_MINUS_ONE) begin : g_minus_one
            assign raw = 64'(field_i) + 64'd1;
        end else if (ENC == rdiv_pkg::ENC_DIRECT) begin : g_direct
            assign raw = 64'(field_i);
        end else if (ENC == rdiv_pkg::ENC_POW2) begin : g_pow2
            assign raw = 64'd1 << field_i;
        end else begin : g_table
            assign raw = 64'(DIV_TABLE[field_i]);
        end

        if (ENC == rdiv_pkg::ENC_TABLE) begin : g_chk_table
            // zero entry marks an unusable index
            assign legal_o = (raw != 64'd0);
        end else begin : g_chk_range
            assign legal_o = (raw != 64'd0) &&
                             (raw >= 64'(MIN_DIV)) &&
                             (raw <= 64'(MAX_DIV));
        end
    endgenerate

    assign div_o = raw[DIV_W-1:0];

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl #(
    parameter int unsigned FIELD_LSB = 4,
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned DIV_W = 8,
    parameter bit LATCH_EN = 1'b1,
    parameter int unsigned LATCH_BIT = 31
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic [FIELD_W-1:0] field_o,
    input  logic [DIV_W-1:0]   dec_div_i,
    input  logic               dec_legal_i,
    input  logic               take_i,
    output logic               pend_vld_o,
    output logic [DIV_W-1:0]   pend_div_o,
    output logic               err_o
);

    typedef struct packed {
        logic [31:0]      word;
        logic             pend_vld;
        logic [DIV_W-1:0] pend_div;
        logic             err;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     commit;

    assign field_o = wdata_i[FIELD_LSB +: FIELD_W];
    assign commit  = !LATCH_EN || wdata_i[LATCH_BIT];

    always_comb begin
        s_d = s_q;
        if (take_i) begin
            s_d.pend_vld = 1'b0;
        end
        if (we_i) begin
            s_d.word = wdata_i;
            if (commit) begin
                if (dec_legal_i) begin
                    s_d.pend_div = dec_div_i;
                    s_d.pend_vld = 1'b1;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o    = s_q.word;
    assign pend_vld_o = s_q.pend_vld;
    assign pend_div_o = s_q.pend_div;
    assign err_o      = s_q.err;

    // R9: error flag never drops once raised
    a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.err |=> s_q.err);

    // R9: refused commit raises the flag
    a_r9_illegal_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && commit && !dec_legal_i) |=> s_q.err);

    // R8: a write without the commit bit leaves the pending divisor alone
    a_r8_latch_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (LATCH_EN && we_i && !wdata_i[LATCH_BIT]) |=> $stable(s_q.pend_div));

    // R5: a legal decode never yields a zero divisor
    a_r5_legal_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_legal_i |-> (dec_div_i != '0));

endmodule

// File: rtl/rdiv_gen.sv
module rdiv_gen #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned RST_DIV = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pend_vld_i,
    input  logic [DIV_W-1:0] pend_div_i,
    output logic             take_o,
    output logic             out_o,
    output logic             bypass_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic             out;
        logic             byp;
    } gen_st_t;

    gen_st_t          s_d, s_q;
    logic             boundary;
    logic [DIV_W-1:0] nxt_act;

    always_comb begin
        boundary = (s_q.cnt == s_q.act - DIV_W'(1));
        take_o   = boundary && pend_vld_i;
        nxt_act  = take_o ? pend_div_i : s_q.act;
        s_d      = s_q;
        s_d.act  = nxt_act;
        s_d.cnt  = boundary ? '0 : s_q.cnt + DIV_W'(1);
        // high for the first floor(N/2) input cycles of each period
        s_d.out  = (s_d.cnt < (nxt_act >> 1));
        s_d.byp  = (nxt_act == DIV_W'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
            s_q.act <= DIV_W'(RST_DIV);
            s_q.out <= (RST_DIV >= 2);
            s_q.byp <= (RST_DIV == 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign out_o    = s_q.out;
    assign bypass_o = s_q.byp;

    // R13: the running divisor only changes right after a period's last cycle
    a_r13_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.act != $past(s_q.act)) |-> ($past(s_q.cnt) == $past(s_q.act) - DIV_W'(1)));

    // R10: the last cycle of a divided period is low
    a_r10_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.byp && (s_q.cnt == s_q.act - DIV_W'(1))) |-> !s_q.out);

    // R11: pass-through keeps the counter parked
    a_r11_bypass_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.byp |-> (s_q.cnt == '0));

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter rdiv_pkg::enc_e ENC = rdiv_pkg::ENC_MINUS_ONE,
    parameter int unsigned FIELD_LSB = 4,
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned DIV_W = 8,
    parameter int unsigned MIN_DIV = 1,
    parameter int unsigned MAX_DIV = 12,
    parameter bit LATCH_EN = 1'b1,
    parameter int unsigned LATCH_BIT = 31,
    parameter int unsigned RST_DIV = 2,
    parameter logic [(1<<FIELD_W)-1:0][DIV_W-1:0] DIV_TABLE =
        128'h0000_0000_0000_0000_0000_000A_0600_0804
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_we_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        div_clk_o,
    output logic        cfg_err_o
);

    logic [FIELD_W-1:0] field;
    logic [DIV_W-1:0]   dec_div;
    logic               dec_legal;
    logic               take;
    logic               pend_vld;
    logic [DIV_W-1:0]   pend_div;
    logic               out_q;
    logic               bypass;

    rdiv_decode #(
        .ENC(ENC), .FIELD_W(FIELD_W), .DIV_W(DIV_W),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_TABLE(DIV_TABLE)
    ) u_decode (
        .field_i(field), .div_o(dec_div), .legal_o(dec_legal)
    );

    rdiv_ctrl #(
        .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .DIV_W(DIV_W),
        .LATCH_EN(LATCH_EN), .LATCH_BIT(LATCH_BIT)
    ) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .field_o(field), .dec_div_i(dec_div),
        .dec_legal_i(dec_legal), .take_i(take), .pend_vld_o(pend_vld),
        .pend_div_o(pend_div), .err_o(cfg_err_o)
    );

    rdiv_gen #(
        .DIV_W(DIV_W), .RST_DIV(RST_DIV)
    ) u_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .pend_vld_i(pend_vld),
        .pend_div_i(pend_div), .take_o(take), .out_o(out_q), .bypass_o(bypass)
    );

    // Divisor 1 routes the input clock through; the select only flips at a
    // rising edge that the divided output also makes.
    assign div_clk_o = bypass ? clk_i : out_q;

endmodule

// File: tb/ratio_divider_bench.sv
module ratio_divider_bench;

    logic        clk;
    logic        rst_n;
    logic [3:0]  we;
    logic [31:0] wd [4];
    logic [31:0] rd [4];
    logic [3:0]  dclk;
    logic [3:0]  err;

    int checks = 0;
    int errors = 0;
    bit busy   = 1'b0;

    typedef struct {
        int    idx;
        int    hi;
        int    per;
        string req;
    } exp_t;
    exp_t q[$];

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // inst 0: plus-one, field [7:4], commit bit 31, max 12
    ratio_divider u_ratio_divider (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we[0]), .reg_wdata_i(wd[0]),
        .reg_rdata_o(rd[0]), .div_clk_o(dclk[0]), .cfg_err_o(err[0]));

    // inst 1: direct, field [3:0], no commit bit, max 15
    ratio_divider #(.ENC(rdiv_pkg::ENC_DIRECT), .FIELD_LSB(0), .MAX_DIV(15),
                    .LATCH_EN(1'b0)) u_dir (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we[1]), .reg_wdata_i(wd[1]),
        .reg_rdata_o(rd[1]), .div_clk_o(dclk[1]), .cfg_err_o(err[1]));

    // inst 2: power of two, field [11:8], max 8
    ratio_divider #(.ENC(rdiv_pkg::ENC_POW2), .FIELD_LSB(8), .MAX_DIV(8),
                    .LATCH_EN(1'b0)) u_pow (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we[2]), .reg_wdata_i(wd[2]),
        .reg_rdata_o(rd[2]), .div_clk_o(dclk[2]), .cfg_err_o(err[2]));

    // inst 3: table, field [3:0], entries 0:4 1:8 2:0 3:6 4:10
    ratio_divider #(.ENC(rdiv_pkg::ENC_TABLE), .FIELD_LSB(0),
                    .LATCH_EN(1'b0)) u_tbl (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we[3]), .reg_wdata_i(wd[3]),
        .reg_rdata_o(rd[3]), .div_clk_o(dclk[3]), .cfg_err_o(err[3]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [31:0] v);
        @(negedge clk);
        we[i] = 1'b1;
        wd[i] = v;
        @(negedge clk);
        we[i] = 1'b0;
    endtask

    // driver: push expected period shapes, then wait for the monitor
    task automatic expect_div(input int i, input int n, input string req, input int settle);
        exp_t e;
        repeat (settle) @(posedge clk);
        e.idx = i; e.hi = n / 2; e.per = n; e.req = req;
        q.push_back(e);
        if (settle != 0) q.push_back(e);
        while (q.size() != 0 || busy) @(posedge clk);
    endtask

    task automatic check_bypass(input int i, input string req);
        repeat (40) @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #2;
            chk(dclk[i] == 1'b1, req, int'(dclk[i]), 1);
            @(negedge clk); #2;
            chk(dclk[i] == 1'b0, req, int'(dclk[i]), 0);
        end
    endtask

    task automatic sample(input int i, output logic s);
        @(posedge clk); #1;
        s = dclk[i];
    endtask

    task automatic measure(input int i, output int hi, output int per);
        logic s;
        int   lo;
        int   guard;
        hi = 0; lo = 0; guard = 0;
        sample(i, s);
        while (s != 1'b0 && guard < 300) begin sample(i, s); guard++; end
        while (s != 1'b1 && guard < 300) begin sample(i, s); guard++; end
        while (s == 1'b1 && guard < 300) begin hi++; sample(i, s); guard++; end
        while (s == 1'b0 && guard < 300) begin lo++; sample(i, s); guard++; end
        per = hi + lo;
    endtask

    // monitor: pop expected shape, measure, compare
    initial begin
        exp_t e;
        int   hi;
        int   per;
        forever begin
            while (q.size() == 0) @(posedge clk);
            busy = 1'b1;
            e = q.pop_front();
            measure(e.idx, hi, per);
            chk(hi == e.hi, {e.req, " high"}, hi, e.hi);
            chk(per == e.per, {e.req, " period"}, per, e.per);
            busy = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        we = '0;
        for (int i = 0; i < 4; i++) wd[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(err == 4'b0, "R1 err", int'(err), 0);
        chk(rd[0] == 32'h0, "R1 rdata", int'(rd[0]), 0);
        expect_div(0, 2, "R1", 10);

        // R2 plus-one decode, R12 readback
        wr(0, 32'h8000_0030);
        chk(rd[0] == 32'h8000_0030, "R12 rdata", int'(rd[0]), 32'h8000_0030);
        expect_div(0, 4, "R2", 40);
        wr(0, 32'h8000_0040);
        expect_div(0, 5, "R10 odd", 40);

        // R8 write without commit bit: stored only
        wr(0, 32'h0000_0020);
        chk(rd[0] == 32'h0000_0020, "R12 rdata", int'(rd[0]), 32'h20);
        expect_div(0, 5, "R8 hold", 40);
        wr(0, 32'h8000_0020);
        expect_div(0, 3, "R8 commit", 40);

        // R7 unrelated bits ignored
        wr(0, 32'h8ABC_D01F);
        expect_div(0, 2, "R7", 40);

        // R6 / R9 over max: refused, sticky, old divisor kept
        chk(err[0] == 1'b0, "R9 pre", int'(err[0]), 0);
        wr(0, 32'h8000_00C0);
        chk(err[0] == 1'b1, "R6 err", int'(err[0]), 1);
        expect_div(0, 2, "R9 keep", 40);
        wr(0, 32'h8000_0050);
        chk(err[0] == 1'b1, "R9 sticky", int'(err[0]), 1);
        expect_div(0, 6, "R10 even", 40);

        // R11 pass-through and back
        wr(0, 32'h8000_0000);
        check_bypass(0, "R11");
        wr(0, 32'h8000_0020);
        expect_div(0, 3, "R11 exit", 40);

        // R3 direct
        wr(1, 32'h0000_0003);
        expect_div(1, 3, "R3", 40);
        wr(1, 32'h0000_0000);
        chk(err[1] == 1'b1, "R3 zero err", int'(err[1]), 1);
        expect_div(1, 3, "R3 keep", 40);
        wr(1, 32'h0000_0001);
        check_bypass(1, "R3 R11");

        // R4 power of two
        wr(2, 32'h0000_0200);
        expect_div(2, 4, "R4", 40);
        wr(2, 32'h0000_0300);
        expect_div(2, 8, "R4", 40);
        wr(2, 32'h0000_0400);
        chk(err[2] == 1'b1, "R6 pow err", int'(err[2]), 1);
        expect_div(2, 8, "R6 keep", 40);
        wr(2, 32'h0000_0000);
        check_bypass(2, "R4 R11");

        // R5 table
        wr(3, 32'h0000_0001);
        expect_div(3, 8, "R5", 40);
        wr(3, 32'h0000_0002);
        chk(err[3] == 1'b1, "R5 zero err", int'(err[3]), 1);
        expect_div(3, 8, "R5 keep", 40);
        wr(3, 32'h0000_0003);
        expect_div(3, 6, "R5", 40);

        // R13 first full period after commit already has new length
        wr(3, 32'h0000_0000);
        expect_div(3, 4, "R13", 0);
        wr(3, 32'h0000_0004);
        expect_div(3, 10, "R13", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule